// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The table is addressed by a few low bits of the branch address, joined with a short shift register. That register holds the directions of the most recently resolved branches, from anywhere in the program. Because the recent history picks among several counters for the same address set, one branch can be predicted from what its neighbours just did. No tag is stored, so branches whose addresses share a set share counters and can disturb each other.

The fetch side presents an address on the lookup port and reads back a taken or not-taken guess in the same cycle. The guess is combinational from the table state. When a branch resolves, the execute side presents its address and real direction on the update port. The selected counter is trained on the next clock edge, and the direction is then shifted into the history. With the history width set to zero, the block becomes a plain address-indexed table of 2-bit counters. The default size is 1024 counters: 8 address bits and 2 history bits.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not-taken) and the history holds 0, so every lookup returns not-taken.
- R2: The lookup result is the upper bit of the addressed counter: counter values 2 and 3 give taken (1), values 0 and 1 give not-taken (0).
- R3: An update with taken = 1 adds one to the addressed counter, which saturates at 3.
- R4: An update with taken = 0 subtracts one from the addressed counter, which saturates at 0.
- R5: A counter at 3 keeps predicting taken after one not-taken update, and predicts not-taken only after a second consecutive one.
- R6: The counter address is {pc[PC_LSB +: SET_BITS], history}, with the history in the low bits. All other address bits are ignored, so addresses that differ only there get the same prediction.
- R7: An update trains only the one counter addressed by its own address and the history as it stood before that update.
- R8: On each update the history shifts left by one, and the real direction enters bit 0 (1 = taken). Lookups never change the history.
- R9: With HIST_BITS = 0 the block acts as a table of 2-bit counters addressed by the address bits alone.
- R10: An update accepted at a clock edge is visible on the lookup output from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_pc | input | PC_W | Branch address to predict |
| lookup_taken | output | 1 | Predicted direction, 1 = taken |
| train_valid | input | 1 | A resolved branch is presented this cycle |
| train_pc | input | PC_W | Address of the resolved branch |
| train_taken | input | 1 | Real direction of the resolved branch, 1 = taken |

## Verification
The bench builds two small copies side by side, each with 2 set bits and a 12-bit address. One has 2 history bits, giving 16 counters. The other has no history, giving 4 counters. At this size the bench can probe every set after every training step and compare each counter against its own arithmetic model. That covers every history pattern and both saturation limits. Lookups also carry random upper and lower address bits, so aliasing through the ignored bits is exercised on every probe.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef logic [1:0] sat2_t;

   localparam sat2_t CTR_INIT = 2'd1;

   function automatic sat2_t sat2_step(sat2_t cur, logic up);
      sat2_t nxt;
      if (up) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
      else    nxt = (cur == 2'd0) ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/bp_history_reg.sv
module bp_history_reg #(
   parameter int HIST_BITS = 2,
   localparam int HW = (HIST_BITS > 0) ? HIST_BITS : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          shift_in,
   output logic [HW-1:0] hist_o
);

   generate
      if (HIST_BITS == 0) begin : g_none
         assign hist_o = '0;
      end else begin : g_reg
         logic [HW-1:0] hist_q;
         if (HIST_BITS == 1) begin : g_one
            always_ff @(posedge clk) begin
               if (!rst_n)        hist_q <= '0;
               else if (shift_en) hist_q <= shift_in;
            end
         end else begin : g_many
            always_ff @(posedge clk) begin
               if (!rst_n)        hist_q <= '0;
               else if (shift_en) hist_q <= {hist_q[HW-2:0], shift_in};
            end
            assert_hist_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
               shift_en |=> hist_q[HW-1:1] == $past(hist_q[HW-2:0]));
         end
         assign hist_o = hist_q;

         assert_hist_newest_R8: assert property (@(posedge clk) disable iff (!rst_n)
            shift_en |=> hist_q[0] == $past(shift_in));
         assert_hist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !shift_en |=> $stable(hist_q));
      end
   endgenerate

endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
   import bp_pkg::*;
#(
   parameter int IDX_W = 10,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);

   sat2_t ctr [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ctr[i] <= CTR_INIT;
      end else if (wr_en) begin
         ctr[wr_idx] <= sat2_step(ctr[wr_idx], wr_taken);
      end
   end

   assign rd_taken = ctr[rd_idx][1];

   // Assertion support: remember the last write to check its effect.
   logic             chk_v;
   logic             chk_up;
   logic [IDX_W-1:0] chk_idx;
   sat2_t            chk_old;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_v   <= 1'b0;
         chk_up  <= 1'b0;
         chk_idx <= '0;
         chk_old <= CTR_INIT;
      end else begin
         chk_v   <= wr_en;
         chk_up  <= wr_taken;
         chk_idx <= wr_idx;
         chk_old <= ctr[wr_idx];
      end
   end

   assert_ctr_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && chk_up && chk_old != 2'd3) |-> ctr[chk_idx] == chk_old + 2'd1);
   assert_ctr_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && chk_up && chk_old == 2'd3) |-> ctr[chk_idx] == 2'd3);
   assert_ctr_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && !chk_up && chk_old != 2'd0) |-> ctr[chk_idx] == chk_old - 2'd1);
   assert_ctr_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && !chk_up && chk_old == 2'd0) |-> ctr[chk_idx] == 2'd0);

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
   parameter int PC_W      = 32,
   parameter int PC_LSB    = 2,
   parameter int SET_BITS  = 8,
   parameter int HIST_BITS = 2,
   localparam int IDX_W = SET_BITS + HIST_BITS,
   localparam int HW    = (HIST_BITS > 0) ? HIST_BITS : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lookup_pc,
   output logic            lookup_taken,
   input  logic            train_valid,
   input  logic [PC_W-1:0] train_pc,
   input  logic            train_taken
);

   initial begin
      assert (SET_BITS >= 1) else $error("SET_BITS must be at least 1");
      assert (HIST_BITS >= 0 && HIST_BITS <= 12) else $error("HIST_BITS out of range");
      assert (PC_LSB + SET_BITS <= PC_W) else $error("set field exceeds address width");
   end

   logic [HW-1:0]    hist;
   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] wr_idx;

   bp_history_reg #(.HIST_BITS(HIST_BITS)) hist_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (train_valid),
      .shift_in (train_taken),
      .hist_o   (hist)
   );

   generate
      if (HIST_BITS == 0) begin : g_flat
         assign rd_idx = lookup_pc[PC_LSB +: SET_BITS];
         assign wr_idx = train_pc[PC_LSB +: SET_BITS];
      end else begin : g_corr
         assign rd_idx = {lookup_pc[PC_LSB +: SET_BITS], hist};
         assign wr_idx = {train_pc[PC_LSB +: SET_BITS], hist};
      end
   endgenerate

   bp_counter_table #(.IDX_W(IDX_W)) table_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_taken (lookup_taken),
      .wr_en    (train_valid),
      .wr_idx   (wr_idx),
      .wr_taken (train_taken)
   );

endmodule

// File: tb/corr_branch_predictor_tb.sv
`timescale 1ns/1ps
module corr_branch_predictor_tb_top;

   localparam int PC_W = 12;
   localparam int LSB  = 2;
   localparam int SETB = 2;
   localparam int NSET = 1 << SETB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PC_W-1:0] lookup_pc = '0;
   logic [PC_W-1:0] train_pc = '0;
   logic train_valid = 1'b0;
   logic train_taken = 1'b0;
   logic pred_corr, pred_flat;

   always #2 clk = ~clk;

   corr_branch_predictor #(.PC_W(PC_W), .PC_LSB(LSB), .SET_BITS(SETB), .HIST_BITS(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .lookup_taken(pred_corr),
      .train_valid(train_valid), .train_pc(train_pc), .train_taken(train_taken));

   corr_branch_predictor #(.PC_W(PC_W), .PC_LSB(LSB), .SET_BITS(SETB), .HIST_BITS(0)) dut_flat_i (
      .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .lookup_taken(pred_flat),
      .train_valid(train_valid), .train_pc(train_pc), .train_taken(train_taken));

   int n_chk = 0;
   int n_fail = 0;
   int m_corr [NSET*4];
   int m_flat [NSET];
   int m_hist = 0;
   logic [31:0] lfsr = 32'h1ACE_5EED;

   function automatic logic [PC_W-1:0] mkpc(int set, logic [31:0] junk);
      logic [PC_W-1:0] p;
      p = junk[PC_W-1:0];
      p[LSB +: SETB] = set[SETB-1:0];
      return p;
   endfunction

   task automatic step_lfsr();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
   endtask

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Train with one resolved branch; model follows R3/R4/R7/R8.
   task automatic train(int set, bit tk);
      int ci;
      step_lfsr();
      @(negedge clk);
      train_pc = mkpc(set, lfsr);
      train_taken = tk;
      train_valid = 1'b1;
      @(negedge clk);
      train_valid = 1'b0;
      ci = set * 4 + m_hist;
      if (tk) begin
         if (m_corr[ci] < 3) m_corr[ci]++;
         if (m_flat[set] < 3) m_flat[set]++;
      end else begin
         if (m_corr[ci] > 0) m_corr[ci]--;
         if (m_flat[set] > 0) m_flat[set]--;
      end
      m_hist = ((m_hist << 1) | int'(tk)) & 3;
   endtask

   // Look up every set with random don't-care address bits.
   task automatic probe(string tag);
      for (int s = 0; s < NSET; s++) begin
         step_lfsr();
         lookup_pc = mkpc(s, lfsr);
         #0.3;
         check(tag, int'(pred_corr), int'(m_corr[s*4 + m_hist] >= 2));
         check("R9", int'(pred_flat), int'(m_flat[s] >= 2));
      end
   endtask

   task automatic run_all();
      for (int i = 0; i < NSET*4; i++) m_corr[i] = 1;
      for (int i = 0; i < NSET; i++) m_flat[i] = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      probe("R1");
      // R3 / R2: climb set 1 to saturation
      for (int k = 0; k < 4; k++) begin train(1, 1'b1); probe("R3"); end
      probe("R2");
      // R4: fall to the floor
      for (int k = 0; k < 5; k++) begin train(1, 1'b0); probe("R4"); end
      // R5: hysteresis on set 2
      for (int k = 0; k < 3; k++) train(2, 1'b1);
      probe("R5");
      train(2, 1'b0); probe("R5");
      train(2, 1'b0); probe("R5");
      // R10: visible right after the training edge
      train(3, 1'b1); probe("R10");
      // R6: many lookups with random ignored bits
      for (int k = 0; k < 8; k++) probe("R6");
      // R7 / R8: history-correlated patterns, then random stream
      for (int k = 0; k < 40; k++) begin train(0, (k % 3) != 2); probe("R7"); end
      for (int k = 0; k < 40; k++) begin train(k % NSET, k[1] ^ k[0]); probe("R8"); end
      for (int k = 0; k < 300; k++) begin
         step_lfsr();
         train(int'(lfsr[5:4]), lfsr[9] | lfsr[3]);
         probe("R7");
         probe("R8");
      end
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule